// File: doc/BRIEF.md
# Arbiter Slot Table Builder

This engine fills the slot table of a time-division memory arbiter. On a start pulse it reads one requested slot count per client, a mask of active clients and a count of spare slots, and works out which client owns each of the table's slots. Clients that asked for a share are spread over the table at even spacing. Active clients that asked for nothing get one spare slot each, for as long as spare slots remain. Every slot still empty after that goes to the active clients in turn. The finished table is streamed out one entry per clock as a slot index and client pair, and a done pulse follows the last entry.

A small combinational admission check comes with the engine. It turns a bandwidth request into a slot count using an integer ratio against the region's total bandwidth. It flags a request that would push the assigned total past the table size, so that software can refuse the request before it rebuilds the table. Client identifiers run from 0 to NUM_CLIENTS-1. Inside the engine, an empty table entry holds the all-ones client code.

Top module: `slot_table_builder`

## Requirements
- R1: While reset is held and after it is released, `wr_en`, `done` and `busy` are low until a start pulse arrives.
- R2: A `start` pulse while idle begins a build and raises `busy`. A `start` pulse while `busy` is high is ignored, and the build in progress writes the same 64 entries it would have written otherwise.
- R3: Clients are placed in ascending index order. A client requesting N > 0 slots tries positions 0, then each later position reached by adding 64/N (integer division) after a placement. An occupied position is skipped by moving forward one position. This is done whether or not the client is active.
- R4: An active client with a request of zero gets exactly one slot, at the first free position from 0, but only while the spare-slot count (latched from `unused_slots` at start) is above zero. Each such grant lowers the count by one. Inactive zero-request clients get no slot in this pass.
- R5: After placement, each slot still empty is filled in ascending slot order. It gets the first active client found by searching from a pointer that starts at 0 at every build. The pointer then moves to the client after the one chosen, wrapping from NUM_CLIENTS-1 to 0.
- R6: When no client is active, each empty slot is filled with the pointer value itself, and the pointer still advances by one.
- R7: Each build produces exactly 64 `wr_en` strobes on consecutive clocks, with `wr_slot` counting 0 to 63, and `wr_client` always below NUM_CLIENTS.
- R8: `done` is high for exactly one cycle: the cycle after the strobe for slot 63. `busy` falls in that same cycle.
- R9: The admission slot count is 0 for zero bandwidth. It is 64 when the bandwidth exceeds the maximum. Otherwise it is 64 / (max / bandwidth), using integer division in both places.
- R10: `adm_reject` is high exactly when `adm_assigned` plus the admission slot count is greater than 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a build (ignored while busy) |
| req_counts | input | NUM_CLIENTS*CNT_W | Requested slot count per client, client k at bits [k*CNT_W +: CNT_W]; held stable while busy |
| active_mask | input | NUM_CLIENTS | Bit k high when client k is active; held stable while busy |
| unused_slots | input | CNT_W | Spare slots available for zero-request clients, latched at start |
| busy | output | 1 | Build in progress |
| wr_en | output | 1 | Table write strobe |
| wr_slot | output | SLOT_W | Slot index being written |
| wr_client | output | CLI_W | Client owning that slot |
| done | output | 1 | One-cycle pulse after the last write |
| adm_bandwidth | input | BW_W | Requested bandwidth |
| adm_max_bw | input | BW_W | Total bandwidth of the region |
| adm_assigned | input | CNT_W | Slots already assigned to other clients |
| adm_slots | output | CNT_W | Slot count equal to the request |
| adm_reject | output | 1 | Request would overflow the table |

## Verification
On every cycle the assertions check the shape of the output stream. Slot indices step by one. Client codes stay in range. No write happens outside a build, and done comes only after slot 63 and is never held for two cycles. The actual owner written into each slot can only be shown by the bench's scenarios, which compare against a behavioural model. These cover spacing with collisions, spare-slot rationing among zero-request clients, round-robin fill with and without active clients, and a start pulse repeated during a build. The admission ratio and the overflow boundary are also checked only by scenarios.

// File: rtl/slot_tbl_pkg.sv
package slot_tbl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ENTER = 3'd1,
      ST_PLACE = 3'd2,
      ST_FILL  = 3'd3,
      ST_FIN   = 3'd4
   } build_state_e;
endpackage

// File: rtl/slot_adm_check.sv
module slot_adm_check #(
   parameter int NUM_SLOTS = 64,
   parameter int BW_W      = 32,
   parameter int CNT_W     = 7
) (
   input  logic [BW_W-1:0]  bandwidth,
   input  logic [BW_W-1:0]  max_bw,
   input  logic [CNT_W-1:0] assigned,
   output logic [CNT_W-1:0] slots,
   output logic             reject
);
   logic [BW_W-1:0]  ratio;
   logic [BW_W-1:0]  quot;
   logic [CNT_W:0]   total;

   always_comb begin
      ratio = '0;
      quot  = '0;
      if (bandwidth == '0) begin
         slots = '0;
      end else begin
         ratio = max_bw / bandwidth;
         if (ratio == '0) begin
            slots = CNT_W'(NUM_SLOTS);
         end else begin
            quot  = BW_W'(NUM_SLOTS) / ratio;
            slots = quot[CNT_W-1:0];
         end
      end
      total  = {1'b0, assigned} + {1'b0, slots};
      reject = total > (CNT_W+1)'(NUM_SLOTS);
   end
endmodule

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
   parameter int NUM_CLIENTS = 14,
   parameter int CLI_W       = 4
) (
   input  logic [NUM_CLIENTS-1:0] active,
   input  logic [CLI_W-1:0]       ptr,
   output logic [CLI_W-1:0]       pick,
   output logic [CLI_W-1:0]       next_ptr
);
   always_comb begin
      pick = ptr;
      for (int k = NUM_CLIENTS - 1; k >= 0; k--) begin
         int idx;
         idx = (int'(ptr) + k) % NUM_CLIENTS;
         if (active[idx]) pick = CLI_W'(idx);
      end
      next_ptr = (int'(pick) == NUM_CLIENTS - 1) ? '0 : pick + 1'b1;
   end
endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
   import slot_tbl_pkg::*;
#(
   parameter int NUM_SLOTS   = 64,
   parameter int NUM_CLIENTS = 14,
   parameter int BW_W        = 32,
   parameter int CNT_W       = $clog2(NUM_SLOTS) + 1,
   parameter int SLOT_W      = $clog2(NUM_SLOTS),
   parameter int CLI_W       = $clog2(NUM_CLIENTS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [NUM_CLIENTS*CNT_W-1:0] req_counts,
   input  logic [NUM_CLIENTS-1:0]       active_mask,
   input  logic [CNT_W-1:0]             unused_slots,
   output logic                         busy,
   output logic                         wr_en,
   output logic [SLOT_W-1:0]            wr_slot,
   output logic [CLI_W-1:0]             wr_client,
   output logic                         done,
   input  logic [BW_W-1:0]              adm_bandwidth,
   input  logic [BW_W-1:0]              adm_max_bw,
   input  logic [CNT_W-1:0]             adm_assigned,
   output logic [CNT_W-1:0]             adm_slots,
   output logic                         adm_reject
);
   localparam logic [CLI_W-1:0] EMPTY    = {CLI_W{1'b1}};
   localparam int               POS_W    = CNT_W + 1;
   localparam logic [CLI_W-1:0] LAST_CLI = CLI_W'(NUM_CLIENTS - 1);

   initial begin
      assert (NUM_SLOTS >= 2 && (1 << SLOT_W) == NUM_SLOTS)
         else $error("NUM_SLOTS must be a power of two");
      assert (NUM_CLIENTS >= 2 && NUM_CLIENTS < (1 << CLI_W))
         else $error("CLI_W must leave room for the empty code");
      assert ((1 << (CNT_W - 1)) >= NUM_SLOTS)
         else $error("CNT_W too narrow for NUM_SLOTS");
   end

   build_state_e             state;
   logic [CLI_W-1:0]         tbl [NUM_SLOTS];
   logic [CLI_W-1:0]         cli;
   logic [POS_W-1:0]         pos;
   logic [CNT_W-1:0]         ival;
   logic [CNT_W-1:0]         spare;
   logic [CLI_W-1:0]         rr_ptr;
   logic [SLOT_W-1:0]        fidx;
   logic [CNT_W-1:0]         cur_req;
   logic [CLI_W-1:0]         rr_pick_c;
   logic [CLI_W-1:0]         rr_next_c;
   logic                     last_cli;

   assign cur_req  = req_counts[int'(cli)*CNT_W +: CNT_W];
   assign last_cli = (cli == LAST_CLI);
   assign busy     = (state != ST_IDLE);

   slot_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .CLI_W(CLI_W)) u_rr (
      .active   (active_mask),
      .ptr      (rr_ptr),
      .pick     (rr_pick_c),
      .next_ptr (rr_next_c)
   );

   slot_adm_check #(.NUM_SLOTS(NUM_SLOTS), .BW_W(BW_W), .CNT_W(CNT_W)) u_adm (
      .bandwidth (adm_bandwidth),
      .max_bw    (adm_max_bw),
      .assigned  (adm_assigned),
      .slots     (adm_slots),
      .reject    (adm_reject)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cli       <= '0;
         pos       <= '0;
         ival      <= '0;
         spare     <= '0;
         rr_ptr    <= '0;
         fidx      <= '0;
         wr_en     <= 1'b0;
         wr_slot   <= '0;
         wr_client <= '0;
         done      <= 1'b0;
         for (int s = 0; s < NUM_SLOTS; s++) tbl[s] <= EMPTY;
      end else begin
         wr_en <= 1'b0;
         done  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  for (int s = 0; s < NUM_SLOTS; s++) tbl[s] <= EMPTY;
                  spare <= unused_slots;
                  cli   <= '0;
                  state <= ST_ENTER;
               end
            end
            ST_ENTER: begin
               pos <= '0;
               if (cur_req != '0) begin
                  ival  <= CNT_W'(NUM_SLOTS) / cur_req;
                  state <= ST_PLACE;
               end else if (active_mask[cli] && spare != '0) begin
                  spare <= spare - 1'b1;
                  ival  <= CNT_W'(NUM_SLOTS);
                  state <= ST_PLACE;
               end else if (last_cli) begin
                  rr_ptr <= '0;
                  fidx   <= '0;
                  state  <= ST_FILL;
               end else begin
                  cli <= cli + 1'b1;
               end
            end
            ST_PLACE: begin
               if (pos >= POS_W'(NUM_SLOTS)) begin
                  if (last_cli) begin
                     rr_ptr <= '0;
                     fidx   <= '0;
                     state  <= ST_FILL;
                  end else begin
                     cli   <= cli + 1'b1;
                     state <= ST_ENTER;
                  end
               end else if (tbl[pos[SLOT_W-1:0]] != EMPTY) begin
                  pos <= pos + 1'b1;
               end else begin
                  tbl[pos[SLOT_W-1:0]] <= cli;
                  pos <= pos + POS_W'(ival);
               end
            end
            ST_FILL: begin
               wr_en   <= 1'b1;
               wr_slot <= fidx;
               if (tbl[fidx] == EMPTY) begin
                  wr_client <= rr_pick_c;
                  rr_ptr    <= rr_next_c;
               end else begin
                  wr_client <= tbl[fidx];
               end
               if (fidx == SLOT_W'(NUM_SLOTS - 1)) state <= ST_FIN;
               else fidx <= fidx + 1'b1;
            end
            ST_FIN: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: consecutive strobes walk the slot index upward by one
   a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_slot == $past(wr_slot) + 1'b1));

   // R7: every written owner is a real client code
   a_r7_client_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_client) < NUM_CLIENTS));

   // R2: writes only come out of a running build
   a_r2_wr_in_build: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(busy));

   // R8: done follows the strobe for the final slot
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_en) && $past(wr_slot) == SLOT_W'(NUM_SLOTS - 1) && !busy));

   // R8: done lasts a single cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/slot_table_builder_bench.sv
module slot_table_builder_bench;
   localparam int NS = 64;
   localparam int NC = 14;
   localparam int CW = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NC*CW-1:0] req_counts = '0;
   logic [NC-1:0]   active_mask = '0;
   logic [CW-1:0]   unused_slots = '0;
   logic            busy, wr_en, done, adm_reject;
   logic [5:0]      wr_slot;
   logic [3:0]      wr_client;
   logic [31:0]     adm_bandwidth = '0, adm_max_bw = '0;
   logic [CW-1:0]   adm_assigned = '0, adm_slots;

   int errors = 0;
   int checks = 0;
   int exp_tbl [NS];
   int req_m [NC];
   int wr_idx;
   bit mon_on = 0;
   bit prev_last = 0;
   bit got_done = 0;
   string tag = "R3";

   always #2 clk = ~clk;

   slot_table_builder u_slot_table_builder (
      .clk, .rst_n, .start, .req_counts, .active_mask, .unused_slots,
      .busy, .wr_en, .wr_slot, .wr_client, .done,
      .adm_bandwidth, .adm_max_bw, .adm_assigned, .adm_slots, .adm_reject
   );

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   function automatic void build_model(input int unused);
      int sp;
      sp = unused;
      for (int s = 0; s < NS; s++) exp_tbl[s] = -1;
      for (int c = 0; c < NC; c++) begin
         int step, p;
         if (req_m[c] == 0) begin
            if (!active_mask[c] || sp <= 0) continue;
            sp--;
            step = NS;
         end else step = NS / req_m[c];
         p = 0;
         while (p < NS) begin
            if (exp_tbl[p] >= 0) p++;
            else begin exp_tbl[p] = c; p += step; end
         end
      end
      begin
         int ptr;
         ptr = 0;
         for (int s = 0; s < NS; s++) begin
            if (exp_tbl[s] < 0) begin
               int first;
               first = ptr;
               while (!active_mask[ptr]) begin
                  ptr = (ptr + 1) % NC;
                  if (ptr == first) break;
               end
               exp_tbl[s] = ptr;
               ptr = (ptr + 1) % NC;
            end
         end
      end
   endfunction

   always @(negedge clk) begin
      if (mon_on) begin
         if (wr_en) begin
            chk(wr_idx < NS && int'(wr_slot) == wr_idx, "R7 slot", int'(wr_slot), wr_idx);
            if (wr_idx < NS)
               chk(int'(wr_client) == exp_tbl[wr_idx], tag, int'(wr_client), exp_tbl[wr_idx]);
            wr_idx++;
         end
         if (done) begin
            chk(wr_idx == NS && prev_last && !busy, "R8 done", wr_idx, NS);
            got_done = 1;
         end
         prev_last = wr_en && wr_slot == 6'd63;
      end
   end

   task automatic run_build(input string t, input int unused, input bit restart);
      for (int c = 0; c < NC; c++) req_counts[c*CW +: CW] = CW'(req_m[c]);
      unused_slots = CW'(unused);
      build_model(unused);
      tag = t;
      wr_idx = 0;
      got_done = 0;
      prev_last = 0;
      mon_on = 1;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk(busy, "R2 busy", int'(busy), 1);
      if (restart) begin
         repeat (30) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk); #1 start = 1'b0;
      end
      while (!got_done) @(posedge clk);
      repeat (3) @(posedge clk);
      mon_on = 0;
      chk(wr_idx == NS, "R7 count", wr_idx, NS);
   endtask

   task automatic adm(input int bw, input int mx, input int as);
      int ex, r;
      adm_bandwidth = bw; adm_max_bw = mx; adm_assigned = CW'(as);
      if (bw == 0) ex = 0;
      else begin r = mx / bw; ex = (r == 0) ? NS : NS / r; end
      #1;
      chk(int'(adm_slots) == ex, "R9 slots", int'(adm_slots), ex);
      chk(adm_reject == (as + ex > NS), "R10 reject", int'(adm_reject), int'(as + ex > NS));
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!wr_en && !done && !busy, "R1 reset", int'({wr_en, done, busy}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!wr_en && !done && !busy, "R1 idle", int'({wr_en, done, busy}), 0);

      // R3 spacing with R4 spare grants and R5 fill
      foreach (req_m[c]) req_m[c] = 0;
      req_m[0] = 16; req_m[1] = 8; req_m[3] = 4;
      active_mask = 14'b00_1100_0000_0111;
      run_build("R3", 64 - 28, 1'b0);

      // R6 nothing active
      foreach (req_m[c]) req_m[c] = 0;
      active_mask = '0;
      run_build("R6", 64, 1'b0);

      // R3 collisions, R4 rationing to one zero-request client
      foreach (req_m[c]) req_m[c] = 0;
      req_m[0] = 3; req_m[1] = 5; req_m[2] = 7;
      active_mask = 14'b10_0001_0011_0000;
      run_build("R4", 1, 1'b0);

      // full table, no spare left for zero-request client
      foreach (req_m[c]) req_m[c] = 0;
      req_m[0] = 32; req_m[1] = 32;
      active_mask = 14'b00_0000_0010_0000;
      run_build("R4", 0, 1'b0);

      // R5 sparse active set, R2 restart ignored during build
      foreach (req_m[c]) req_m[c] = 0;
      req_m[6] = 2;
      active_mask = 14'b10_0000_0000_1001;
      run_build("R5", 0, 1'b1);
      run_build("R2", 0, 1'b1);

      adm(25000000, 100000000, 0);
      adm(0, 100000000, 64);
      adm(200000000, 100000000, 0);
      adm(30000000, 100000000, 10);
      adm(25000000, 100000000, 48);
      adm(25000000, 100000000, 49);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule